// File: doc/BRIEF.md
# Chopping Current Regulator Sequencer

This block is the per-channel switch sequencer of a constant-current H-bridge driver. An external oscillator marks the start of each chopping period with a one-cycle pulse. An external comparator reports whether the coil current has reached the set-point. From these the block chooses, cycle by cycle, which of the four bridge switches conduct. Every period opens with a forced drive interval in which the comparator cannot end the drive. What the comparator reported during that interval decides the rest of the period. If the current was below target at any point, drive continues until the target is reached, the coil then recirculates through both low switches, and a short reverse-decay tail closes the period. If the current was at or above target throughout, the bridge reverse-decays until the next period starts.

Any change of switch pattern, whether from a new mode or a new current direction, is separated by a fixed interval with all four switches off. An enable input can force all switches off at once, while the sequencer keeps running underneath. A zero-magnitude request taken at the period start holds the bridge in low-side recirculation for the whole period.

Top module: `chop_ctrl`

## Requirements
- R1: After reset all four gate outputs are 0, and they stay 0 until the first period-start pulse.
- R2: A period-start pulse with `mag_zero` low forces the drive pattern for BLANK_CYC (default 8) cycles of the internal sequence, whatever `at_setpoint` does. The pattern reaches the gates one cycle after the pulse is sampled, or after the dead interval if another pattern was showing.
- R3: If `at_setpoint` was 0 in any blanking cycle, drive continues after blanking until `at_setpoint` is 1. The next pattern is then low-side recirculation.
- R4: If `at_setpoint` was 1 in every blanking cycle, reverse decay follows blanking and holds until the next period-start pulse.
- R5: Recirculation gives way to reverse decay once PERIOD_CYC-TAIL_CYC cycles (default 152) have passed since the start pulse. Reverse decay then holds until the next start pulse. A drive phase that reaches the set-point after that count goes straight to reverse decay.
- R6: Every change of the applied {mode, direction} pair from a driving pattern shows exactly DEAD_CYC (default 3) cycles with all gates 0 before the new pattern. Leaving the all-off idle state needs no dead interval.
- R7: Gate patterns as {gate_hi_a, gate_hi_b, gate_lo_a, gate_lo_b}. With `cur_dir`=0 (current from A to B): drive 1001, recirculate 0011, reverse decay 0110. With `cur_dir`=1: drive 0110, recirculate 0011, reverse decay 1001. No leg ever has its high and low switch on together.
- R8: While `out_en` is 0, all gates are 0 in the same cycle, and the sequence state keeps advancing.
- R9: `mag_zero`=1 sampled with a period-start pulse selects recirculation for the whole period, with no drive phase and no decay tail.
- R10: A period-start pulse arriving mid-period restarts blanking at once, from whatever mode is active.
- R11: After the drive phase of a period has ended, `at_setpoint` cannot bring drive back before the next start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_start | input | 1 | One-cycle pulse opening a chopping period |
| at_setpoint | input | 1 | 1 when coil current is at or above the set-point |
| cur_dir | input | 1 | Current direction: 0 = A to B, 1 = B to A |
| out_en | input | 1 | 0 forces every gate off |
| mag_zero | input | 1 | Zero-magnitude request, sampled with period_start |
| gate_hi_a | output | 1 | High switch, leg A |
| gate_hi_b | output | 1 | High switch, leg B |
| gate_lo_a | output | 1 | Low switch, leg A |
| gate_lo_b | output | 1 | Low switch, leg B |

## Verification
The assertions assume that all inputs are synchronous to `clk` and settle before the rising edge. They also assume that `mag_zero` is meaningful only in a cycle that carries `period_start`. They place no limit on how often the comparator toggles or how close together start pulses arrive. The stimulus changes inputs only at the falling edge and keeps start pulses one cycle wide. It mixes nominal-length periods with early restarts, random comparator toggling, direction flips and enable drop-outs, so that dead intervals overlap period boundaries.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    DRV_OFF    = 2'd0,
    DRV_CHARGE = 2'd1,
    DRV_SLOW   = 2'd2,
    DRV_FAST   = 2'd3
  } drv_mode_e;

  typedef struct packed {
    drv_mode_e mode;
    logic      dir;
  } drv_key_t;

  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_BLANK  = 3'd1,
    SQ_CHARGE = 3'd2,
    SQ_SLOW   = 3'd3,
    SQ_FAST   = 3'd4,
    SQ_HOLD   = 3'd5
  } seq_state_e;

endpackage

// File: rtl/chop_seq.sv
module chop_seq
  import chop_pkg::*;
#(
  parameter int BLANK_CYC  = 8,
  parameter int TAIL_CYC   = 8,
  parameter int PERIOD_CYC = 160
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      period_start,
  input  logic      at_setpoint,
  input  logic      mag_zero,
  output drv_mode_e req_mode
);

  localparam int CNT_W = $clog2(PERIOD_CYC + 1);
  localparam logic [CNT_W-1:0] BLANK_LAST = CNT_W'(BLANK_CYC - 1);
  localparam logic [CNT_W-1:0] TAIL_AT    = CNT_W'(PERIOD_CYC - TAIL_CYC);
  localparam logic [CNT_W-1:0] PCNT_MAX   = CNT_W'(PERIOD_CYC);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] pcnt_q, pcnt_d;
  logic             low_seen_q, low_seen_d;

  // next-state: a start pulse overrides everything (restart / abort)
  always_comb begin
    st_d       = st_q;
    low_seen_d = low_seen_q;
    pcnt_d     = (pcnt_q == PCNT_MAX) ? pcnt_q : pcnt_q + 1'b1;
    if (period_start) begin
      st_d       = mag_zero ? SQ_HOLD : SQ_BLANK;
      pcnt_d     = '0;
      low_seen_d = 1'b0;
    end else begin
      unique case (st_q)
        SQ_BLANK: begin
          low_seen_d = low_seen_q | ~at_setpoint;
          if (pcnt_q == BLANK_LAST)
            st_d = low_seen_d ? SQ_CHARGE : SQ_FAST;
        end
        SQ_CHARGE: begin
          if (at_setpoint)
            st_d = (pcnt_q >= TAIL_AT) ? SQ_FAST : SQ_SLOW;
        end
        SQ_SLOW: begin
          if (pcnt_q >= TAIL_AT)
            st_d = SQ_FAST;
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= SQ_IDLE;
      pcnt_q     <= '0;
      low_seen_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      pcnt_q     <= pcnt_d;
      low_seen_q <= low_seen_d;
    end
  end

  always_comb begin
    unique case (st_q)
      SQ_BLANK, SQ_CHARGE: req_mode = DRV_CHARGE;
      SQ_SLOW,  SQ_HOLD:   req_mode = DRV_SLOW;
      SQ_FAST:             req_mode = DRV_FAST;
      default:             req_mode = DRV_OFF;
    endcase
  end

  // R2: comparator cannot end blanking early
  p_blank_forced_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_BLANK && pcnt_q != BLANK_LAST && !period_start) |=> (st_q == SQ_BLANK));

  // R3: drive holds until the set-point is reached
  p_charge_until_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_CHARGE && !at_setpoint && !period_start) |=> (st_q == SQ_CHARGE));

  // R4 / R5: reverse decay is held until the next period
  p_fast_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_FAST && !period_start) |=> (st_q == SQ_FAST));

  // R9: zero magnitude selects the hold state
  p_zero_mag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && mag_zero) |=> (st_q == SQ_HOLD));

  // R10: start pulse restarts blanking from any state
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && !mag_zero) |=> (st_q == SQ_BLANK && pcnt_q == '0));

  // R11: no return to drive within the same period
  p_no_recharge_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == SQ_SLOW || st_q == SQ_FAST || st_q == SQ_HOLD) && !period_start)
      |=> !(st_q == SQ_BLANK || st_q == SQ_CHARGE));

endmodule

// File: rtl/chop_deadtime.sv
module chop_deadtime
  import chop_pkg::*;
#(
  parameter int DEAD_CYC = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  drv_mode_e req_mode,
  input  logic      req_dir,
  output drv_key_t  act
);

  drv_key_t req_key;
  assign req_key = '{mode: req_mode, dir: req_dir};

  generate
    if (DEAD_CYC == 0) begin : g_nodead
      drv_key_t act_q;
      always_ff @(posedge clk) begin
        if (!rst_n) act_q <= '{mode: DRV_OFF, dir: 1'b0};
        else        act_q <= req_key;
      end
      assign act = act_q;
    end else begin : g_dead
      localparam int DW = $clog2(DEAD_CYC + 1);
      localparam logic [DW-1:0] DEAD_LAST = DW'(DEAD_CYC - 1);

      drv_key_t      act_q, act_d;
      logic          in_dead_q, in_dead_d;
      logic [DW-1:0] dcnt_q, dcnt_d;

      always_comb begin
        act_d     = act_q;
        in_dead_d = in_dead_q;
        dcnt_d    = dcnt_q;
        if (in_dead_q) begin
          if (dcnt_q == DEAD_LAST) begin
            act_d     = req_key;
            in_dead_d = 1'b0;
          end else begin
            dcnt_d = dcnt_q + 1'b1;
          end
        end else if (req_key != act_q) begin
          if (act_q.mode == DRV_OFF) begin
            act_d = req_key;
          end else begin
            act_d     = '{mode: DRV_OFF, dir: act_q.dir};
            in_dead_d = 1'b1;
            dcnt_d    = '0;
          end
        end
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          act_q     <= '{mode: DRV_OFF, dir: 1'b0};
          in_dead_q <= 1'b0;
          dcnt_q    <= '0;
        end else begin
          act_q     <= act_d;
          in_dead_q <= in_dead_d;
          dcnt_q    <= dcnt_d;
        end
      end

      assign act = act_q;

      // R6: a driving pattern only ever changes by passing through all-off
      p_through_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q.mode != DRV_OFF) |=> (act_q == $past(act_q) || act_q.mode == DRV_OFF));

      // R6: the off interval is not cut short
      p_dead_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_dead_q && dcnt_q != DEAD_LAST) |=> (act_q.mode == DRV_OFF));
    end
  endgenerate

endmodule

// File: rtl/chop_gate_map.sv
module chop_gate_map
  import chop_pkg::*;
(
  input  drv_key_t   act,
  input  logic       out_en,
  output logic [1:0] gate_hi,
  output logic [1:0] gate_lo
);

  // leg 0 = A, leg 1 = B; the source leg is the one current leaves through
  generate
    for (genvar g = 0; g < 2; g++) begin : g_leg
      logic src;
      assign src = (g == 0) ? ~act.dir : act.dir;
      always_comb begin
        gate_hi[g] = 1'b0;
        gate_lo[g] = 1'b0;
        if (out_en) begin
          unique case (act.mode)
            DRV_CHARGE: begin gate_hi[g] = src;  gate_lo[g] = ~src; end
            DRV_SLOW:   begin gate_hi[g] = 1'b0; gate_lo[g] = 1'b1; end
            DRV_FAST:   begin gate_hi[g] = ~src; gate_lo[g] = src;  end
            default:    begin gate_hi[g] = 1'b0; gate_lo[g] = 1'b0; end
          endcase
        end
      end
    end
  endgenerate

endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
  import chop_pkg::*;
#(
  parameter int BLANK_CYC  = 8,
  parameter int TAIL_CYC   = 8,
  parameter int DEAD_CYC   = 3,
  parameter int PERIOD_CYC = 160
) (
  input  logic clk,
  input  logic rst_n,
  input  logic period_start,
  input  logic at_setpoint,
  input  logic cur_dir,
  input  logic out_en,
  input  logic mag_zero,
  output logic gate_hi_a,
  output logic gate_hi_b,
  output logic gate_lo_a,
  output logic gate_lo_b
);

  drv_mode_e  req_mode;
  drv_key_t   act;
  logic [1:0] hi, lo;

  chop_seq #(
    .BLANK_CYC (BLANK_CYC),
    .TAIL_CYC  (TAIL_CYC),
    .PERIOD_CYC(PERIOD_CYC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .period_start(period_start),
    .at_setpoint (at_setpoint),
    .mag_zero    (mag_zero),
    .req_mode    (req_mode)
  );

  chop_deadtime #(
    .DEAD_CYC(DEAD_CYC)
  ) u_dead (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_mode(req_mode),
    .req_dir (cur_dir),
    .act     (act)
  );

  chop_gate_map u_map (
    .act    (act),
    .out_en (out_en),
    .gate_hi(hi),
    .gate_lo(lo)
  );

  assign gate_hi_a = hi[0];
  assign gate_hi_b = hi[1];
  assign gate_lo_a = lo[0];
  assign gate_lo_b = lo[1];

  // R8: disabled output means every switch off
  p_disable_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> !(gate_hi_a || gate_hi_b || gate_lo_a || gate_lo_b));

  // R7: never both switches of one leg
  p_leg_safe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi_a && gate_lo_a) && !(gate_hi_b && gate_lo_b));

endmodule

// File: tb/chop_ctrl_test.sv
`timescale 1ns/1ps
module chop_ctrl_test;
  localparam int BLANK  = 8;
  localparam int TAIL   = 8;
  localparam int DEAD   = 3;
  localparam int PERIOD = 160;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ps = 1'b0, at = 1'b0, dir = 1'b0, en = 1'b1, mz = 1'b0;
  logic hi_a, hi_b, lo_a, lo_b;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  chop_ctrl #(.BLANK_CYC(BLANK), .TAIL_CYC(TAIL), .DEAD_CYC(DEAD), .PERIOD_CYC(PERIOD)) uut (
    .clk(clk), .rst_n(rst_n), .period_start(ps), .at_setpoint(at), .cur_dir(dir),
    .out_en(en), .mag_zero(mz), .gate_hi_a(hi_a), .gate_hi_b(hi_b),
    .gate_lo_a(lo_a), .gate_lo_b(lo_b));

  // reference model: states 0 idle,1 blank,2 drive,3 recirc,4 rev decay,5 hold
  // modes 0 off,1 drive,2 recirc,3 reverse decay
  int m_st, m_pc, m_am, m_dcnt;
  bit m_seen, m_ad, m_dead;

  function automatic int smode(int st);
    case (st)
      1, 2:    return 1;
      3, 5:    return 2;
      4:       return 3;
      default: return 0;
    endcase
  endfunction

  // R7 table, bits {hi_a, hi_b, lo_a, lo_b}
  function automatic logic [3:0] gexp(int md, bit d, logic e);
    if (!e || md == 0) return 4'b0000;
    if (md == 2) return 4'b0011;
    if (md == 1) return d ? 4'b0110 : 4'b1001;
    return d ? 4'b1001 : 4'b0110;
  endfunction

  task automatic model_reset();
    m_st = 0; m_pc = 0; m_seen = 0; m_am = 0; m_ad = 0; m_dead = 0; m_dcnt = 0;
  endtask

  task automatic model_step();
    int rm;
    bit seen_n;
    rm = smode(m_st);
    if (m_dead) begin
      if (m_dcnt == DEAD - 1) begin m_dead = 0; m_am = rm; m_ad = dir; end
      else m_dcnt++;
    end else if (rm != m_am || dir != m_ad) begin
      if (m_am == 0) begin m_am = rm; m_ad = dir; end
      else begin m_am = 0; m_dead = 1; m_dcnt = 0; end
    end
    if (ps) begin
      m_st = mz ? 5 : 1; m_pc = 0; m_seen = 0;
    end else begin
      case (m_st)
        1: begin
          seen_n = m_seen | ~at;
          m_seen = seen_n;
          if (m_pc == BLANK - 1) m_st = seen_n ? 2 : 4;
        end
        2: if (at) m_st = (m_pc >= PERIOD - TAIL) ? 4 : 3;
        3: if (m_pc >= PERIOD - TAIL) m_st = 4;
        default: ;
      endcase
      if (m_pc < PERIOD) m_pc++;
    end
  endtask

  task automatic check_out(input string tag);
    logic [3:0] got, exp;
    string t;
    t = en ? tag : "R8";
    got = {hi_a, hi_b, lo_a, lo_b};
    exp = gexp(m_am, m_ad, en);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s gates actual %b expected %b at %0t", t, got, exp, $time);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    if (rst_n) model_step(); else model_reset();
    @(negedge clk);
    check_out(tag);
  endtask

  task automatic start_pulse(input string tag);
    ps = 1'b1;
    tick(tag);
    ps = 1'b0;
    mz = 1'b0;
  endtask

  initial begin
    int seed_v;
    int len;
    seed_v = $urandom(32'h5eed);
    model_reset();
    // R1: reset state
    repeat (4) tick("R1");
    rst_n = 1'b1;
    repeat (20) tick("R1");

    // R4: comparator high through blanking
    at = 1'b1;
    start_pulse("R4");
    repeat (PERIOD - 1) tick("R4");

    // R3 then R5: low through blanking, reach set-point, recirculate, tail
    at = 1'b0;
    start_pulse("R3");
    repeat (40) tick("R3");
    at = 1'b1;
    repeat (PERIOD - 41) tick("R5");

    // R2: a single low blanking cycle still decides drive
    at = 1'b1;
    start_pulse("R2");
    for (int i = 0; i < BLANK; i++) begin
      at = (i == 3) ? 1'b0 : 1'b1;
      tick("R2");
    end
    at = 1'b0;
    repeat (10) tick("R3");
    at = 1'b1;
    repeat (PERIOD - BLANK - 11) tick("R5");

    // R9: zero magnitude, comparator noise ignored
    mz = 1'b1;
    at = 1'b0;
    start_pulse("R9");
    for (int i = 0; i < PERIOD - 1; i++) begin
      at = 1'($urandom_range(0, 1));
      tick("R9");
    end

    // R10: early restart mid drive
    at = 1'b0;
    start_pulse("R10");
    repeat (25) tick("R10");
    start_pulse("R10");
    repeat (30) tick("R10");
    at = 1'b1;
    repeat (PERIOD - 1) tick("R10");

    // R6 and R11: direction flip during recirculation, comparator toggling after drive
    at = 1'b0;
    start_pulse("R6");
    repeat (15) tick("R6");
    at = 1'b1;
    repeat (20) tick("R11");
    dir = 1'b1;
    for (int i = 0; i < 30; i++) begin
      at = (i % 3 == 0);
      tick("R11");
    end
    dir = 1'b0;
    repeat (PERIOD - 67) tick("R6");

    // R8: enable drop-out while the sequence runs
    at = 1'b0;
    start_pulse("R8");
    repeat (5) tick("R8");
    en = 1'b0;
    repeat (20) tick("R8");
    at = 1'b1;
    en = 1'b1;
    repeat (PERIOD - 26) tick("R8");

    // constrained random periods
    for (int p = 0; p < 60; p++) begin
      len = ($urandom_range(0, 5) == 0) ? int'($urandom_range(12, PERIOD - 10)) : PERIOD;
      mz = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 3) == 0) dir = ~dir;
      at = 1'($urandom_range(0, 1));
      start_pulse("R7");
      for (int c = 1; c < len; c++) begin
        if ($urandom_range(0, 7) == 0) at = ~at;
        if ($urandom_range(0, 63) == 0) dir = ~dir;
        en = ($urandom_range(0, 31) != 0);
        tick("R7");
      end
      en = 1'b1;
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule